// File: doc/BRIEF.md
# Timestamped Event Target

This block is one endpoint behind a shared real-time I/O command port. An initiator presents a 2-bit operation code together with a 24-bit target select, a 64-bit event time, a data word and an 8-bit address. Output events are held in a small queue and leave the block on a release strobe in the exact cycle when an internal free-running 64-bit time counter equals their event time. Input events are captured with the counter value of their arrival cycle and handed back to read operations. Buffer-space queries are answered with a cautious count of free output slots.

The upper byte of the target select names a destination. The lower 16 bits name a channel, which travels with each output event. A write follows a three-cycle pattern. The initiator drives the event time and the target select, then adds the rest of the payload and the write code, and then inspects the write status. A read may stall: its wait flag stays up until an input event can be handed back or the read deadline passes.

Top module: `tev_target`

## Requirements
- R1: While reset is asserted and after it is released, `wr_status`, `rd_status`, `space_valid` and `rel_valid` are 0. `now_time` starts from 0 and advances by exactly 1 per clock.
- R2: The operation code is nop=0, write=1, read=2, buffer query=3. A write (code 1) whose `target_sel[23:16]` equals `DEST_ID` and whose `wr_stamp` exceeds `now_time + 1` in the command cycle is queued, and `wr_status` is 0 in the following cycle.
- R3: Each queued event is released in write order. `rel_valid` is high for one cycle, in the cycle where `now_time` equals its event time, with `rel_stamp`, `rel_chan` (= `target_sel[15:0]`), `rel_addr` and `rel_data` carrying its fields.
- R4: A write whose event time is at most `now_time + 1` is dropped. In the next cycle it sets `wr_status` bit 1 (late), which stays set until the next write command is taken.
- R5: A write that finds the output queue full sets `wr_status` bit 0 (busy) from the next cycle. The bit stays set until a slot frees; the held event is then queued and released at its time.
- R6: A buffer query makes `space_valid` high for exactly one cycle, the next one. `space_count` then equals the depth minus the queued events, or 0 if the queue is full or a write is being held.
- R7: A read (code 2) with an input event queued pops the oldest one. In the next cycle `rd_status` is 0, `rd_data` is its data and `rd_stamp` is the `now_time` value of the cycle in which `ev_valid` was high.
- R8: A read that finds no input event sets `rd_status` to 4 (bit 2, wait) from the next cycle. It holds that value until an event arrives, then returns that event with `rd_status` 0.
- R9: While a read waits, once `now_time` has reached `rd_timeout` the read ends with `rd_status` = 1 (bit 0 only). This first shows in the cycle where `now_time` equals `rd_timeout + 1`. Bits 0 and 1 are never set together.
- R10: An input event that arrives when the input queue is full is discarded. The next read returns `rd_status` = 2 (bit 1 only), pops nothing and clears the condition; later reads return the queued events in order.
- R11: A write or read whose destination byte differs from `DEST_ID` queues and pops nothing. A write sets `wr_status` = 4 (bit 2). A read sets `rd_status` = 8 (bit 3) and nothing else.
- R12: A nop (code 0) leaves every status, the queues and the release output unchanged, whatever the payload inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_op | input | 2 | Operation code |
| target_sel | input | 24 | Destination byte [23:16] and channel [15:0] |
| wr_stamp | input | 64 | Event time of a write |
| wr_data | input | WDATA_W | Data of a write |
| wr_addr | input | 8 | Address of a write |
| wr_status | output | 3 | Bit 0 busy, bit 1 late, bit 2 unreachable |
| space_valid | output | 1 | Buffer query answer strobe |
| space_count | output | 16 | Free output slots, cautious |
| rd_timeout | input | 64 | Deadline of a read |
| rd_data | output | 32 | Data of the returned input event |
| rd_stamp | output | 64 | Arrival time of the returned input event |
| rd_status | output | 4 | Bit 0 timeout, bit 1 overflow, bit 2 wait, bit 3 unreachable |
| ev_valid | input | 1 | Input event strobe |
| ev_data | input | 32 | Input event data |
| rel_valid | output | 1 | Output event release strobe |
| rel_stamp | output | 64 | Event time of the released event |
| rel_chan | output | 16 | Channel of the released event |
| rel_addr | output | 8 | Address of the released event |
| rel_data | output | WDATA_W | Data of the released event |
| now_time | output | 64 | Free-running time counter |

## Verification
The bench probes the lateness boundary from both sides. An event time of now+1 must be refused as late, while now+2 must be accepted and still leave the block in the cycle its time comes up; a comparison off by one would either drop a legal event or release it a cycle late. It fills the output queue and adds one more write, expecting the busy flag and then the held event's release, where a design that overwrote or lost the held entry would release the wrong data. It overflows the input queue and checks that the first read reports only overflow and pops nothing; a design that popped, or kept the flag after reporting it, would show the wrong data on later reads or a stale bit 1. It also checks that a timed-out read ends in the exact cycle implied by its deadline and that a wrong destination leaves both queues untouched.

// File: rtl/tev_pkg.sv
package tev_pkg;

  localparam int STAMP_W = 64;
  localparam int SEL_W   = 24;
  localparam int CHAN_W  = 16;
  localparam int DEST_W  = SEL_W - CHAN_W;
  localparam int ADDR_W  = 8;
  localparam int IDATA_W = 32;
  localparam int CNT_W   = 16;

  // operation codes on the command port
  typedef enum logic [1:0] {
    OP_NOP   = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_SPACE = 2'd3
  } tev_op_e;

  // write status bit positions
  localparam int WS_BUSY    = 0;
  localparam int WS_LATE    = 1;
  localparam int WS_UNREACH = 2;

  // read status bit positions
  localparam int RS_TMO     = 0;
  localparam int RS_OVF     = 1;
  localparam int RS_WAIT    = 2;
  localparam int RS_UNREACH = 3;

endpackage

// File: rtl/tev_fifo.sv
module tev_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [W-1:0]                 push_data,
  input  logic                         pop,
  output logic [W-1:0]                 head,
  output logic                         empty,
  output logic                         full,
  output logic [$clog2(DEPTH+1)-1:0]   level
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] lvl_q, lvl_d;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (lvl_q == '0);
  assign full    = (lvl_q == CW'(DEPTH));
  assign level   = lvl_q;
  assign head    = mem[rp_q];
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_comb begin
    wp_d  = do_push ? bump(wp_q) : wp_q;
    rp_d  = do_pop  ? bump(rp_q) : rp_q;
    lvl_d = lvl_q + CW'(do_push) - CW'(do_pop);
  end

  always_ff @(posedge clk) begin
    if (do_push) begin
      mem[wp_q] <= push_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      lvl_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      lvl_q <= lvl_d;
    end
  end

endmodule

// File: rtl/tev_timebase.sv
module tev_timebase #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] count
);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign count = cnt_q;

endmodule

// File: rtl/tev_out_queue.sv
module tev_out_queue
  import tev_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STAMP_W-1:0] now_time,
  input  logic               wr_req,
  input  logic               dest_ok,
  input  logic [STAMP_W-1:0] wr_stamp,
  input  logic [CHAN_W-1:0]  wr_chan,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               space_req,
  output logic               st_busy,
  output logic               st_late,
  output logic               st_unreach,
  output logic               space_valid,
  output logic [CNT_W-1:0]   space_count,
  output logic               rel_valid,
  output logic [STAMP_W-1:0] rel_stamp,
  output logic [CHAN_W-1:0]  rel_chan,
  output logic [ADDR_W-1:0]  rel_addr,
  output logic [DATA_W-1:0]  rel_data
);

  localparam int CW = $clog2(DEPTH+1);

  typedef struct packed {
    logic [STAMP_W-1:0] stamp;
    logic [CHAN_W-1:0]  chan;
    logic [ADDR_W-1:0]  addr;
    logic [DATA_W-1:0]  data;
  } oev_t;

  localparam int EW = $bits(oev_t);

  oev_t          incoming, head, push_ent;
  oev_t          hold_q, hold_d, rel_q, rel_d;
  logic          hold_v_q, hold_v_d;
  logic          late_q, late_d, unr_q, unr_d;
  logic          sv_q, sv_d, rv_q, rv_d;
  logic [CNT_W-1:0] sc_q, sc_d;
  logic          push, pop, fempty, ffull;
  logic [CW-1:0] level;
  logic [STAMP_W-1:0] now_p1;
  logic          is_late, take, due;
  logic [EW-1:0] head_raw;

  assign incoming = '{stamp: wr_stamp, chan: wr_chan, addr: wr_addr, data: wr_data};
  assign now_p1   = now_time + 1'b1;
  assign is_late  = (wr_stamp <= now_p1);
  assign take     = wr_req && !hold_v_q;
  assign head     = oev_t'(head_raw);
  assign due      = !fempty && (head.stamp <= now_p1);
  assign pop      = due;

  tev_fifo #(.W(EW), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_data (push_ent),
    .pop       (pop),
    .head      (head_raw),
    .empty     (fempty),
    .full      (ffull),
    .level     (level)
  );

  // write acceptance and held-write handling
  always_comb begin
    hold_v_d = hold_v_q;
    hold_d   = hold_q;
    late_d   = late_q;
    unr_d    = unr_q;
    push     = 1'b0;
    push_ent = hold_q;
    if (hold_v_q && !ffull) begin
      push     = 1'b1;
      hold_v_d = 1'b0;
    end
    if (take) begin
      unr_d  = !dest_ok;
      late_d = dest_ok && is_late;
      if (dest_ok && !is_late) begin
        if (ffull) begin
          hold_v_d = 1'b1;
          hold_d   = incoming;
        end else begin
          push     = 1'b1;
          push_ent = incoming;
        end
      end
    end
  end

  // query answer and release stage
  always_comb begin
    sv_d = space_req;
    sc_d = sc_q;
    if (space_req) begin
      sc_d = (hold_v_q || ffull) ? '0 : (CNT_W'(DEPTH) - CNT_W'(level));
    end
    rv_d  = due;
    rel_d = due ? head : rel_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_v_q <= 1'b0;
      hold_q   <= '0;
      late_q   <= 1'b0;
      unr_q    <= 1'b0;
      sv_q     <= 1'b0;
      sc_q     <= '0;
      rv_q     <= 1'b0;
      rel_q    <= '0;
    end else begin
      hold_v_q <= hold_v_d;
      if (take) begin
        hold_q <= hold_d;
      end
      late_q <= late_d;
      unr_q  <= unr_d;
      sv_q   <= sv_d;
      if (space_req) begin
        sc_q <= sc_d;
      end
      rv_q <= rv_d;
      if (due) begin
        rel_q <= rel_d;
      end
    end
  end

  assign st_busy     = hold_v_q;
  assign st_late     = late_q;
  assign st_unreach  = unr_q;
  assign space_valid = sv_q;
  assign space_count = sc_q;
  assign rel_valid   = rv_q;
  assign rel_stamp   = rel_q.stamp;
  assign rel_chan    = rel_q.chan;
  assign rel_addr    = rel_q.addr;
  assign rel_data    = rel_q.data;

endmodule

// File: rtl/tev_in_capture.sv
module tev_in_capture
  import tev_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STAMP_W-1:0] now_time,
  input  logic               ev_valid,
  input  logic [IDATA_W-1:0] ev_data,
  input  logic               rd_req,
  input  logic               dest_ok,
  input  logic [STAMP_W-1:0] rd_timeout,
  output logic [IDATA_W-1:0] rd_data,
  output logic [STAMP_W-1:0] rd_stamp,
  output logic [3:0]         rd_status
);

  localparam int CW = $clog2(DEPTH+1);

  typedef struct packed {
    logic [STAMP_W-1:0] stamp;
    logic [IDATA_W-1:0] data;
  } iev_t;

  localparam int EW = $bits(iev_t);

  iev_t          head, out_q, out_d;
  logic [EW-1:0] head_raw;
  logic          push, pop, fempty, ffull;
  logic [CW-1:0] level;
  logic          wait_q, wait_d, ovf_q, ovf_d, ovf_clr;
  logic [3:0]    st_q, st_d;
  logic [STAMP_W-1:0] tmo_q, tmo_d;

  assign push = ev_valid && !ffull;
  assign head = iev_t'(head_raw);

  tev_fifo #(.W(EW), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_data ({now_time, ev_data}),
    .pop       (pop),
    .head      (head_raw),
    .empty     (fempty),
    .full      (ffull),
    .level     (level)
  );

  always_comb begin
    wait_d  = wait_q;
    st_d    = st_q;
    tmo_d   = tmo_q;
    out_d   = out_q;
    pop     = 1'b0;
    ovf_clr = 1'b0;
    if (wait_q) begin
      if (!fempty) begin
        pop    = 1'b1;
        out_d  = head;
        st_d   = '0;
        wait_d = 1'b0;
      end else if (now_time >= tmo_q) begin
        st_d         = '0;
        st_d[RS_TMO] = 1'b1;
        wait_d       = 1'b0;
      end
    end else if (rd_req) begin
      st_d = '0;
      if (!dest_ok) begin
        st_d[RS_UNREACH] = 1'b1;
      end else if (ovf_q) begin
        st_d[RS_OVF] = 1'b1;
        ovf_clr      = 1'b1;
      end else if (!fempty) begin
        pop   = 1'b1;
        out_d = head;
      end else begin
        st_d[RS_WAIT] = 1'b1;
        wait_d        = 1'b1;
        tmo_d         = rd_timeout;
      end
    end
    if (ev_valid && ffull) begin
      ovf_d = 1'b1;
    end else if (ovf_clr) begin
      ovf_d = 1'b0;
    end else begin
      ovf_d = ovf_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q <= 1'b0;
      st_q   <= '0;
      tmo_q  <= '0;
      out_q  <= '0;
      ovf_q  <= 1'b0;
    end else begin
      wait_q <= wait_d;
      st_q   <= st_d;
      if (rd_req && !wait_q) begin
        tmo_q <= tmo_d;
      end
      if (pop) begin
        out_q <= out_d;
      end
      ovf_q <= ovf_d;
    end
  end

  assign rd_data   = out_q.data;
  assign rd_stamp  = out_q.stamp;
  assign rd_status = st_q;

endmodule

// File: rtl/tev_target.sv
module tev_target
  import tev_pkg::*;
#(
  parameter int          OUT_DEPTH = 4,
  parameter int          IN_DEPTH  = 4,
  parameter int          WDATA_W   = 32,
  parameter logic [7:0]  DEST_ID   = 8'h05
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          cmd_op,
  input  logic [SEL_W-1:0]    target_sel,
  input  logic [STAMP_W-1:0]  wr_stamp,
  input  logic [WDATA_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0]   wr_addr,
  output logic [2:0]          wr_status,
  output logic                space_valid,
  output logic [CNT_W-1:0]    space_count,
  input  logic [STAMP_W-1:0]  rd_timeout,
  output logic [IDATA_W-1:0]  rd_data,
  output logic [STAMP_W-1:0]  rd_stamp,
  output logic [3:0]          rd_status,
  input  logic                ev_valid,
  input  logic [IDATA_W-1:0]  ev_data,
  output logic                rel_valid,
  output logic [STAMP_W-1:0]  rel_stamp,
  output logic [CHAN_W-1:0]   rel_chan,
  output logic [ADDR_W-1:0]   rel_addr,
  output logic [WDATA_W-1:0]  rel_data,
  output logic [STAMP_W-1:0]  now_time
);

  logic [1:0] rs_q;
  logic       rst_sync_n;
  tev_op_e    op;
  logic       dest_ok, is_wr, is_rd, is_sp;
  logic       st_busy, st_late, st_unreach;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= '0;
    end else begin
      rs_q <= {rs_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rs_q[1];

  assign op      = tev_op_e'(cmd_op);
  assign dest_ok = (target_sel[SEL_W-1:CHAN_W] == DEST_ID);
  assign is_wr   = (op == OP_WRITE);
  assign is_rd   = (op == OP_READ);
  assign is_sp   = (op == OP_SPACE);

  tev_timebase #(.W(STAMP_W)) u_time (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .count (now_time)
  );

  tev_out_queue #(.DEPTH(OUT_DEPTH), .DATA_W(WDATA_W)) u_out (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .now_time    (now_time),
    .wr_req      (is_wr),
    .dest_ok     (dest_ok),
    .wr_stamp    (wr_stamp),
    .wr_chan     (target_sel[CHAN_W-1:0]),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .space_req   (is_sp),
    .st_busy     (st_busy),
    .st_late     (st_late),
    .st_unreach  (st_unreach),
    .space_valid (space_valid),
    .space_count (space_count),
    .rel_valid   (rel_valid),
    .rel_stamp   (rel_stamp),
    .rel_chan    (rel_chan),
    .rel_addr    (rel_addr),
    .rel_data    (rel_data)
  );

  tev_in_capture #(.DEPTH(IN_DEPTH)) u_in (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .now_time   (now_time),
    .ev_valid   (ev_valid),
    .ev_data    (ev_data),
    .rd_req     (is_rd),
    .dest_ok    (dest_ok),
    .rd_timeout (rd_timeout),
    .rd_data    (rd_data),
    .rd_stamp   (rd_stamp),
    .rd_status  (rd_status)
  );

  always_comb begin
    wr_status             = '0;
    wr_status[WS_BUSY]    = st_busy;
    wr_status[WS_LATE]    = st_late;
    wr_status[WS_UNREACH] = st_unreach;
  end

endmodule

// File: rtl/tev_target_chk.sv
module tev_target_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  cmd_op,
  input logic [2:0]  wr_status,
  input logic [3:0]  rd_status,
  input logic        space_valid,
  input logic        rel_valid,
  input logic [63:0] rel_stamp,
  input logic [63:0] now_time
);

  // R1: the time counter advances by one per clock once running
  p_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (now_time != 64'd0) |-> (now_time == $past(now_time) + 64'd1));

  // R3: a release coincides with the counter equal to the event time
  p_rel_on_time_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rel_valid |-> (rel_stamp == now_time));

  // R4: the late flag only rises after a write command
  p_late_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_status[1]) |-> ($past(cmd_op) == 2'd1));

  // R6: a query answer follows a query command
  p_space_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    space_valid |-> ($past(cmd_op) == 2'd3));

  // R9: timeout and overflow are never reported together
  p_tmo_ovf_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_status[0] && rd_status[1]));

  // R11: an unreachable read reports nothing else
  p_unreach_alone_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_status[3] |-> (rd_status[2:0] == 3'b000));

endmodule

bind tev_target tev_target_chk i_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .cmd_op      (cmd_op),
  .wr_status   (wr_status),
  .rd_status   (rd_status),
  .space_valid (space_valid),
  .rel_valid   (rel_valid),
  .rel_stamp   (rel_stamp),
  .now_time    (now_time)
);

// File: tb/test_tev_target.sv
module test_tev_target;

  localparam logic [7:0] DEST = 8'h05;

  logic        clk;
  logic        rst_n;
  logic [1:0]  cmd_op;
  logic [23:0] target_sel;
  logic [63:0] wr_stamp;
  logic [31:0] wr_data;
  logic [7:0]  wr_addr;
  logic [2:0]  wr_status;
  logic        space_valid;
  logic [15:0] space_count;
  logic [63:0] rd_timeout;
  logic [31:0] rd_data;
  logic [63:0] rd_stamp;
  logic [3:0]  rd_status;
  logic        ev_valid;
  logic [31:0] ev_data;
  logic        rel_valid;
  logic [63:0] rel_stamp;
  logic [15:0] rel_chan;
  logic [7:0]  rel_addr;
  logic [31:0] rel_data;
  logic [63:0] now_time;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  logic [119:0] rel_exp [$];
  logic [95:0]  in_exp  [$];

  tev_target #(.OUT_DEPTH(4), .IN_DEPTH(4), .WDATA_W(32), .DEST_ID(DEST)) i_tev_target (
    .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .target_sel(target_sel),
    .wr_stamp(wr_stamp), .wr_data(wr_data), .wr_addr(wr_addr),
    .wr_status(wr_status), .space_valid(space_valid), .space_count(space_count),
    .rd_timeout(rd_timeout), .rd_data(rd_data), .rd_stamp(rd_stamp),
    .rd_status(rd_status), .ev_valid(ev_valid), .ev_data(ev_data),
    .rel_valid(rel_valid), .rel_stamp(rel_stamp), .rel_chan(rel_chan),
    .rel_addr(rel_addr), .rel_data(rel_data), .now_time(now_time)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  // release monitor: pops the scoreboard as events leave the block
  always @(negedge clk) begin
    if (rst_n && rel_valid) begin
      if (rel_exp.size() == 0) begin
        chk("R3 unexpected release", 64'd1, 64'd0);
      end else begin
        logic [119:0] e;
        e = rel_exp.pop_front();
        chk("R3 release time", now_time, e[119:56]);
        chk("R3 stamp", rel_stamp, e[119:56]);
        chk("R3 chan", {48'd0, rel_chan}, {48'd0, e[55:40]});
        chk("R3 addr", {56'd0, rel_addr}, {56'd0, e[39:32]});
        chk("R3 data", {32'd0, rel_data}, {32'd0, e[31:0]});
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // write; when rel is set the time is now_time + st in the command cycle
  task automatic do_write(input bit rel, input logic [63:0] st, input logic [31:0] d,
                          input logic [7:0] a, input logic [15:0] ch,
                          input logic [7:0] dest, input bit expect_rel);
    logic [63:0] s;
    @(negedge clk);
    s = rel ? now_time + st : st;
    cmd_op = 2'd1; target_sel = {dest, ch}; wr_stamp = s; wr_data = d; wr_addr = a;
    if (expect_rel) rel_exp.push_back({s, ch, a, d});
    @(negedge clk);
    cmd_op = 2'd0;
  endtask

  task automatic do_query(input logic [15:0] exp_cnt, input string tag);
    @(negedge clk);
    cmd_op = 2'd3; target_sel = {DEST, 16'h0};
    @(negedge clk);
    cmd_op = 2'd0;
    chk({tag, " valid"}, {63'd0, space_valid}, 64'd1);
    chk({tag, " count"}, {48'd0, space_count}, {48'd0, exp_cnt});
    @(negedge clk);
    chk({tag, " one cycle"}, {63'd0, space_valid}, 64'd0);
  endtask

  task automatic ev_pulse(input logic [31:0] d, input bit keep);
    @(negedge clk);
    ev_valid = 1'b1; ev_data = d;
    if (keep) in_exp.push_back({now_time, d});
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  task automatic do_read(input bit rel, input logic [63:0] tmo, input logic [7:0] dest,
                         output logic [63:0] tmo_used);
    @(negedge clk);
    tmo_used = rel ? now_time + tmo : tmo;
    cmd_op = 2'd2; target_sel = {dest, 16'h0}; rd_timeout = tmo_used;
    @(negedge clk);
    cmd_op = 2'd0;
  endtask

  task automatic chk_read_data(input string tag);
    logic [95:0] e;
    if (in_exp.size() == 0) begin
      chk({tag, " scoreboard empty"}, 64'd1, 64'd0);
    end else begin
      e = in_exp.pop_front();
      chk({tag, " data"}, {32'd0, rd_data}, {32'd0, e[31:0]});
      chk({tag, " stamp"}, rd_stamp, e[95:32]);
    end
  endtask

  task automatic wait_drain(input string tag);
    for (int i = 0; i < 400 && rel_exp.size() != 0; i++) @(negedge clk);
    chk(tag, 64'(rel_exp.size()), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual hang expected completion");
    finish_run();
  end

  initial begin
    logic [63:0] t0, tu;
    rst_n = 1'b0; cmd_op = 2'd0; target_sel = '0; wr_stamp = '0; wr_data = '0;
    wr_addr = '0; rd_timeout = '0; ev_valid = 1'b0; ev_data = '0;
    idle(4);
    chk("R1 reset wr_status", {61'd0, wr_status}, 64'd0);
    chk("R1 reset rd_status", {60'd0, rd_status}, 64'd0);
    chk("R1 reset now_time", now_time, 64'd0);
    rst_n = 1'b1;
    idle(4);
    t0 = now_time;
    idle(1);
    chk("R1 counter step", now_time, t0 + 64'd1);
    chk("R1 idle release", {63'd0, rel_valid}, 64'd0);
    chk("R1 idle space", {63'd0, space_valid}, 64'd0);

    // R12: nop with a full write payload does nothing
    @(negedge clk);
    cmd_op = 2'd0; target_sel = {DEST, 16'h1}; wr_stamp = now_time + 30;
    idle(1);
    chk("R12 nop wr_status", {61'd0, wr_status}, 64'd0);
    chk("R12 nop rd_status", {60'd0, rd_status}, 64'd0);
    do_query(16'd4, "R12 nop queue");

    // R2/R3: three ordinary writes
    do_write(1, 20, 32'hA1, 8'h11, 16'h0101, DEST, 1);
    chk("R2 write ok", {61'd0, wr_status}, 64'd0);
    do_write(1, 25, 32'hA2, 8'h12, 16'h0202, DEST, 1);
    do_write(1, 30, 32'hA3, 8'h13, 16'h0303, DEST, 1);
    chk("R2 write ok 3", {61'd0, wr_status}, 64'd0);
    do_query(16'd1, "R6 after three");
    wait_drain("R3 drained");

    // R4: lateness boundary
    do_write(1, 1, 32'hB0, 8'h20, 16'h0010, DEST, 0);
    chk("R4 late now+1", {61'd0, wr_status}, 64'd2);
    idle(3);
    chk("R4 late sticky", {61'd0, wr_status}, 64'd2);
    do_write(1, 2, 32'hB1, 8'h21, 16'h0011, DEST, 1);
    chk("R4 now+2 accepted", {61'd0, wr_status}, 64'd0);
    wait_drain("R4 boundary release");
    do_write(1, 0, 32'hB2, 8'h22, 16'h0012, DEST, 0);
    chk("R4 late now", {61'd0, wr_status}, 64'd2);
    idle(5);
    chk("R4 nothing released", 64'(rel_exp.size()), 64'd0);

    // R5: full queue and held write
    do_write(1, 60, 32'hC0, 8'h30, 16'h0020, DEST, 1);
    do_write(1, 62, 32'hC1, 8'h31, 16'h0021, DEST, 1);
    do_write(1, 64, 32'hC2, 8'h32, 16'h0022, DEST, 1);
    do_write(1, 66, 32'hC3, 8'h33, 16'h0023, DEST, 1);
    chk("R5 fill ok", {61'd0, wr_status}, 64'd0);
    do_write(1, 80, 32'hC4, 8'h34, 16'h0024, DEST, 1);
    chk("R5 busy", {61'd0, wr_status}, 64'd1);
    do_query(16'd0, "R6 held write");
    for (int i = 0; i < 200 && wr_status[0]; i++) @(negedge clk);
    chk("R5 busy clears", {61'd0, wr_status}, 64'd0);
    chk("R5 slot freed first", 64'(rel_exp.size()), 64'd4);
    wait_drain("R5 held released");

    // R11: wrong destination
    do_write(1, 20, 32'hD0, 8'h40, 16'h0030, 8'h06, 0);
    chk("R11 write unreachable", {61'd0, wr_status}, 64'd4);
    idle(30);
    do_query(16'd4, "R11 nothing queued");

    // R7: reads with data
    ev_pulse(32'hE0, 1);
    ev_pulse(32'hE1, 1);
    do_read(1, 50, 8'h06, tu);
    chk("R11 read unreachable", {60'd0, rd_status}, 64'd8);
    do_read(1, 50, DEST, tu);
    chk("R7 status", {60'd0, rd_status}, 64'd0);
    chk_read_data("R7 first");
    do_read(1, 50, DEST, tu);
    chk("R7 status 2", {60'd0, rd_status}, 64'd0);
    chk_read_data("R7 second");

    // R8: waiting read
    do_read(1, 1000, DEST, tu);
    chk("R8 wait", {60'd0, rd_status}, 64'd4);
    idle(5);
    chk("R8 still waiting", {60'd0, rd_status}, 64'd4);
    ev_pulse(32'hE2, 1);
    for (int i = 0; i < 20 && rd_status[2]; i++) @(negedge clk);
    chk("R8 wait ends", {60'd0, rd_status}, 64'd0);
    chk_read_data("R8 data");

    // R9: timeout cycle
    do_read(1, 10, DEST, tu);
    chk("R9 wait", {60'd0, rd_status}, 64'd4);
    for (int i = 0; i < 40 && rd_status == 4'd4; i++) @(negedge clk);
    chk("R9 timeout status", {60'd0, rd_status}, 64'd1);
    chk("R9 timeout cycle", now_time, tu + 64'd1);

    // R10: overflow
    ev_pulse(32'hF0, 1);
    ev_pulse(32'hF1, 1);
    ev_pulse(32'hF2, 1);
    ev_pulse(32'hF3, 1);
    ev_pulse(32'hF4, 0);
    do_read(1, 50, DEST, tu);
    chk("R10 overflow only", {60'd0, rd_status}, 64'd2);
    for (int k = 0; k < 4; k++) begin
      do_read(1, 50, DEST, tu);
      chk("R10 later read status", {60'd0, rd_status}, 64'd0);
      chk_read_data("R10 order");
    end
    do_read(1, 3, DEST, tu);
    for (int i = 0; i < 20 && rd_status == 4'd4; i++) @(negedge clk);
    chk("R10 dropped event absent", {60'd0, rd_status}, 64'd1);

    idle(4);
    finish_run();
  end

endmodule